// File: doc/BRIEF.md
# Descriptor Chain Trigger Sequencer

This block sequences descriptor fetches for a set of descriptor-chain DMA channels (six by default). Software arms channels through a shared, write-only global word of sticky trigger and retrigger bits, sets each channel's enable and pause bits in a per-channel control word, and writes a per-channel chain start address. The sequencer picks one eligible channel at a time in round-robin order. It issues a single-cycle fetch request with the channel index and the descriptor address. Then it waits for the fetch engine to report the outcome of that descriptor.

The outcome tells the sequencer three things: whether the descriptor closed the chain (last, or last of a frame), whether a fetch or validation error occurred, and the next-descriptor pointer carried by the descriptor. A channel whose chain has finished starts again from its start address. A channel in mid-chain continues from the saved pointer. A sticky retrigger bit forces a restart from the start address and is consumed when it is used. A finished chain, or a stop in single-descriptor mode, parks the channel until the next frame tick. Memory access and payload movement belong to other blocks.

Top module: `chan_trig_seq`

## Requirements
- R1: The global word sits at select 0 (group 0, channel 0). A write ORs data bits 11:0 into it and never clears any bit. Bits 0..5 are the per-channel triggers and bits 6..11 the per-channel retriggers. Reading select 0 returns zero.
- R2: A write to a channel's control word (group 1, select = 8 + channel) stores the low 30 data bits, which read back with bits 31:30 zero. The same write clears that channel's trigger bit.
- R3: A channel is eligible only when its trigger bit is set, control bit 0 (enable) is one, control bit 1 (pause) is zero, and the channel is not parked.
- R4: When a channel's chain has finished (which is the case for every channel after reset), its next fetch address is (start_hi << 16) + start_lo. start_hi is written at group 2 (select 16 + channel) and keeps only data bits 15:0. start_lo is written at group 3 (select 24 + channel) and keeps all 32 bits.
- R5: After a descriptor that does not end the chain, the channel's next fetch address is (next_hi << 32) + next_lo, taken from the result.
- R6: A set retrigger bit forces the next fetch of that channel to use the start address. The bit is cleared when that fetch is issued.
- R7: A result with last, frame-end or error set marks the chain finished and parks the channel. A frame_tick pulse releases all parked channels, and the restarted chain fetches from the start address.
- R8: With single_mode high, a result that does not end the chain still parks the channel. After the next frame_tick the channel continues from the saved next pointer.
- R9: Grants rotate in fixed round-robin order starting after the last granted channel. Only one fetch is outstanding at a time, and fetch_req is high for exactly one cycle per grant.
- R10: After reset, fetch_req is low and every control, start and global register reads as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_waddr | input | CW+2 | Write select: group in the top two bits, channel in the low CW bits |
| cfg_wdata | input | 32 | Write data |
| cfg_raddr | input | CW+2 | Read select, same encoding |
| cfg_rdata | output | 32 | Read data (combinational) |
| single_mode | input | 1 | Stop after each descriptor |
| frame_tick | input | 1 | Releases parked channels |
| fetch_req | output | 1 | One-cycle descriptor fetch request |
| fetch_ch | output | CW | Channel of the request |
| fetch_addr | output | AW | Descriptor address of the request |
| res_valid | input | 1 | Outcome of the outstanding fetch |
| res_last | input | 1 | Descriptor was last of chain |
| res_frame_end | input | 1 | Descriptor was last of frame |
| res_err | input | 1 | Fetch or validation error |
| res_next_hi | input | 16 | Upper word of the next-descriptor pointer |
| res_next_lo | input | 32 | Lower word of the next-descriptor pointer |

## Verification
A register write presented before a rising edge is visible on cfg_rdata right after that edge. A write that makes a channel eligible raises fetch_req one edge later, because the grant is registered. A result accepted at an edge frees the sequencer for a new grant, and that grant shows as fetch_req after the following edge. The bench drives inputs and samples outputs on falling edges. It waits for fetch_req with a bounded poll, checks that the request drops on the next falling edge, and checks parked or ineligible states over a fixed window of cycles in which no request may appear.

// File: rtl/chan_seq_pkg.sv
package chan_seq_pkg;
    typedef enum logic [1:0] {
        GRP_GLOBAL  = 2'd0,
        GRP_CTRL    = 2'd1,
        GRP_STRT_HI = 2'd2,
        GRP_STRT_LO = 2'd3
    } cfg_grp_e;

    localparam int TRIG_BITS = 12;
    localparam int CTRL_BITS = 30;
    localparam int HI_BITS   = 16;
endpackage

// File: rtl/cts_rr_arb.sv
module cts_rr_arb #(
    parameter int N  = 6,
    parameter int CW = 3
) (
    input  logic [N-1:0]  elig,
    input  logic [CW-1:0] last_gnt,
    output logic          gnt_valid,
    output logic [CW-1:0] gnt_idx
);
    always_comb begin
        gnt_valid = 1'b0;
        gnt_idx   = '0;
        for (int k = 1; k <= N; k++) begin
            int idx;
            idx = int'(last_gnt) + k;
            if (idx >= N) idx = idx - N;
            if (!gnt_valid && elig[idx]) begin
                gnt_valid = 1'b1;
                gnt_idx   = CW'(idx);
            end
        end
    end
endmodule

// File: rtl/cts_addr_mux.sv
module cts_addr_mux #(
    parameter int N  = 6,
    parameter int AW = 48
) (
    input  logic [N-1:0]        use_start,
    input  logic [N-1:0][15:0]  strt_hi,
    input  logic [N-1:0][31:0]  strt_lo,
    input  logic [N-1:0][AW-1:0] nxt,
    output logic [N-1:0][AW-1:0] cand
);
    for (genvar g = 0; g < N; g++) begin : g_ch
        logic [AW-1:0] start_a;
        assign start_a = (AW'(strt_hi[g]) << 16) + AW'(strt_lo[g]);
        assign cand[g] = use_start[g] ? start_a : nxt[g];
    end
endmodule

// File: rtl/chan_trig_seq.sv
module chan_trig_seq
    import chan_seq_pkg::*;
#(
    parameter int NCH = 6,
    parameter int AW  = 48,
    localparam int CW = $clog2(NCH),
    localparam int SW = CW + 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_we,
    input  logic [SW-1:0] cfg_waddr,
    input  logic [31:0]   cfg_wdata,
    input  logic [SW-1:0] cfg_raddr,
    output logic [31:0]   cfg_rdata,
    input  logic          single_mode,
    input  logic          frame_tick,
    output logic          fetch_req,
    output logic [CW-1:0] fetch_ch,
    output logic [AW-1:0] fetch_addr,
    input  logic          res_valid,
    input  logic          res_last,
    input  logic          res_frame_end,
    input  logic          res_err,
    input  logic [15:0]   res_next_hi,
    input  logic [31:0]   res_next_lo
);
    typedef struct packed {
        logic [TRIG_BITS-1:0]            glb;
        logic [NCH-1:0][CTRL_BITS-1:0]   ctrl;
        logic [NCH-1:0][HI_BITS-1:0]     shi;
        logic [NCH-1:0][31:0]            slo;
        logic [NCH-1:0][AW-1:0]          nxt;
        logic [NCH-1:0]                  fin;
        logic [NCH-1:0]                  park;
        logic                            busy;
        logic                            req;
        logic [CW-1:0]                   ch;
        logic [AW-1:0]                   addr;
        logic [CW-1:0]                   rr;
    } st_t;

    st_t st_q, st_d;

    logic [NCH-1:0]          elig;
    logic [NCH-1:0]          use_start;
    logic [NCH-1:0][AW-1:0]  cand;
    logic                    gnt_valid;
    logic [CW-1:0]           gnt_idx;

    for (genvar g = 0; g < NCH; g++) begin : g_elig
        assign elig[g] = st_q.glb[g] & st_q.ctrl[g][0] & ~st_q.ctrl[g][1] & ~st_q.park[g];
        assign use_start[g] = st_q.fin[g] | st_q.glb[NCH + g];
    end

    cts_rr_arb #(.N(NCH), .CW(CW)) arb_i (
        .elig      (elig),
        .last_gnt  (st_q.rr),
        .gnt_valid (gnt_valid),
        .gnt_idx   (gnt_idx)
    );

    cts_addr_mux #(.N(NCH), .AW(AW)) amux_i (
        .use_start (use_start),
        .strt_hi   (st_q.shi),
        .strt_lo   (st_q.slo),
        .nxt       (st_q.nxt),
        .cand      (cand)
    );

    logic [1:0]    wgrp;
    logic [CW-1:0] wch;
    logic [1:0]    rgrp;
    logic [CW-1:0] rch;
    assign wgrp = cfg_waddr[SW-1:CW];
    assign wch  = cfg_waddr[CW-1:0];
    assign rgrp = cfg_raddr[SW-1:CW];
    assign rch  = cfg_raddr[CW-1:0];

    always_comb begin
        logic done;
        st_d     = st_q;
        st_d.req = 1'b0;
        done     = res_last | res_frame_end | res_err;

        // descriptor outcome
        if (res_valid && st_q.busy) begin
            st_d.busy           = 1'b0;
            st_d.nxt[st_q.ch]   = {res_next_hi, res_next_lo};
            st_d.fin[st_q.ch]   = done;
            if (done || single_mode) st_d.park[st_q.ch] = 1'b1;
        end

        if (frame_tick) st_d.park = '0;

        // grant a new fetch
        if (!st_q.busy && gnt_valid) begin
            st_d.req               = 1'b1;
            st_d.busy              = 1'b1;
            st_d.ch                = gnt_idx;
            st_d.addr              = cand[gnt_idx];
            st_d.fin[gnt_idx]      = 1'b0;
            st_d.glb[NCH + gnt_idx] = 1'b0;
            st_d.rr                = gnt_idx;
        end

        // register writes (applied last so new bits survive a same-cycle consume)
        if (cfg_we) begin
            unique case (cfg_grp_e'(wgrp))
                GRP_GLOBAL: if (wch == '0) st_d.glb = st_d.glb | cfg_wdata[TRIG_BITS-1:0];
                GRP_CTRL: if (int'(wch) < NCH) begin
                    st_d.ctrl[wch] = cfg_wdata[CTRL_BITS-1:0];
                    st_d.glb[wch]  = 1'b0;
                end
                GRP_STRT_HI: if (int'(wch) < NCH) st_d.shi[wch] = cfg_wdata[HI_BITS-1:0];
                GRP_STRT_LO: if (int'(wch) < NCH) st_d.slo[wch] = cfg_wdata;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q     <= '0;
            st_q.fin <= '1;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        cfg_rdata = '0;
        if (int'(rch) < NCH) begin
            unique case (cfg_grp_e'(rgrp))
                GRP_GLOBAL:  cfg_rdata = '0;
                GRP_CTRL:    cfg_rdata = {{(32-CTRL_BITS){1'b0}}, st_q.ctrl[rch]};
                GRP_STRT_HI: cfg_rdata = {{(32-HI_BITS){1'b0}}, st_q.shi[rch]};
                GRP_STRT_LO: cfg_rdata = st_q.slo[rch];
                default:     cfg_rdata = '0;
            endcase
        end
    end

    assign fetch_req  = st_q.req;
    assign fetch_ch   = st_q.ch;
    assign fetch_addr = st_q.addr;
endmodule

// File: rtl/chan_trig_seq_chk.sv
module chan_trig_seq_chk #(
    parameter int NCH = 6,
    parameter int CW  = 3,
    parameter int SW  = 5
) (
    input logic          clk,
    input logic          rst_n,
    input logic [SW-1:0] cfg_raddr,
    input logic [31:0]   cfg_rdata,
    input logic          fetch_req,
    input logic [CW-1:0] fetch_ch
);
    // R9
    req_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_req |=> !fetch_req);

    // R9
    req_ch_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_req |-> (int'(fetch_ch) < NCH));

    // R1
    glb_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_raddr == '0) |-> (cfg_rdata == '0));

    // R2
    ctrl_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_raddr[SW-1:CW] == 2'd1) |-> (cfg_rdata[31:30] == 2'b00));

    // R4
    hi_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_raddr[SW-1:CW] == 2'd2) |-> (cfg_rdata[31:16] == 16'h0));
endmodule

bind chan_trig_seq chan_trig_seq_chk #(.NCH(NCH), .CW(CW), .SW(SW)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_raddr (cfg_raddr),
    .cfg_rdata (cfg_rdata),
    .fetch_req (fetch_req),
    .fetch_ch  (fetch_ch)
);

// File: tb/chan_trig_seq_tb_top.sv
`timescale 1ns/1ps
module chan_trig_seq_tb_top;
    localparam int NCH = 6;
    localparam int AW  = 48;
    localparam int CW  = 3;
    localparam int SW  = 5;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_we = 1'b0;
    logic [SW-1:0] cfg_waddr = '0;
    logic [31:0]   cfg_wdata = '0;
    logic [SW-1:0] cfg_raddr = '0;
    logic [31:0]   cfg_rdata;
    logic          single_mode = 1'b0;
    logic          frame_tick = 1'b0;
    logic          fetch_req;
    logic [CW-1:0] fetch_ch;
    logic [AW-1:0] fetch_addr;
    logic          res_valid = 1'b0;
    logic          res_last = 1'b0;
    logic          res_frame_end = 1'b0;
    logic          res_err = 1'b0;
    logic [15:0]   res_next_hi = '0;
    logic [31:0]   res_next_lo = '0;

    int n_chk = 0;
    int n_err = 0;
    logic [CW-1:0] got_ch;
    logic [AW-1:0] got_addr;

    always #2 clk = ~clk;

    chan_trig_seq #(.NCH(NCH), .AW(AW)) dut_i (.*);

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [SW-1:0] a, input logic [31:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_waddr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic rd(input logic [SW-1:0] a, output logic [31:0] d);
        cfg_raddr = a;
        #0.1;
        d = cfg_rdata;
    endtask

    task automatic tick();
        @(negedge clk); frame_tick = 1'b1;
        @(negedge clk); frame_tick = 1'b0;
    endtask

    task automatic wait_req(input string req, input logic [CW-1:0] ech, input logic [AW-1:0] eaddr);
        bit found = 0;
        for (int i = 0; i < 20 && !found; i++) begin
            @(negedge clk);
            if (fetch_req) begin
                found = 1; got_ch = fetch_ch; got_addr = fetch_addr;
            end
        end
        check({req, " request seen"}, 64'(found), 64'd1);
        if (found) begin
            check({req, " channel"}, 64'(got_ch), 64'(ech));
            check({req, " address"}, 64'(got_addr), 64'(eaddr));
            @(negedge clk);
            check("R9 request one cycle", 64'(fetch_req), 64'd0);
        end
    endtask

    task automatic no_req(input string req);
        int seen = 0;
        for (int i = 0; i < 12; i++) begin
            @(negedge clk);
            if (fetch_req) seen++;
        end
        check({req, " no request"}, 64'(seen), 64'd0);
    endtask

    task automatic respond(input bit last, input bit fend, input bit err,
                           input logic [15:0] nh, input logic [31:0] nl);
        @(negedge clk);
        res_valid = 1'b1; res_last = last; res_frame_end = fend; res_err = err;
        res_next_hi = nh; res_next_lo = nl;
        @(negedge clk);
        res_valid = 1'b0; res_last = 0; res_frame_end = 0; res_err = 0;
    endtask

    task automatic t_reset();
        logic [31:0] d;
        check("R10 fetch_req after reset", 64'(fetch_req), 64'd0);
        rd(5'd8, d);  check("R10 ctrl0 reset", 64'(d), 64'd0);
        rd(5'd16, d); check("R10 start_hi0 reset", 64'(d), 64'd0);
        rd(5'd0, d);  check("R10 global read", 64'(d), 64'd0);
    endtask

    task automatic t_regs();
        logic [31:0] d;
        wr(5'd8, 32'hFFFF_FFFF);
        rd(5'd8, d); check("R2 ctrl low 30 bits", 64'(d), 64'h3FFF_FFFF);
        wr(5'd8, 32'h0);
        wr(5'd16, 32'h0001_ABCD);
        rd(5'd16, d); check("R4 start_hi keeps 16 bits", 64'(d), 64'hABCD);
        wr(5'd24, 32'h0000_0100);
        rd(5'd24, d); check("R4 start_lo", 64'(d), 64'h100);
        wr(5'd0, 32'hFFF);
        rd(5'd0, d); check("R1 global reads zero", 64'(d), 64'd0);
    endtask

    task automatic t_chain0();
        // trigger bits of all channels are now set (R1); only ch0 gets enabled
        wr(5'd8, 32'h3);                    // enable+pause, clears trig0
        wr(5'd0, 32'h1);
        no_req("R3 paused");
        wr(5'd8, 32'h1);                    // clears trig0 again
        no_req("R2 trigger cleared by ctrl write");
        wr(5'd0, 32'h1);
        wait_req("R4 start address", 3'd0, 48'hABCD_0100);
        respond(0, 0, 0, 16'h0012, 32'h3456_7800);
        wait_req("R5 next address", 3'd0, 48'h0012_3456_7800);
        respond(1, 0, 0, 16'h0, 32'h0);
        no_req("R7 parked after last");
        tick();
        wait_req("R7 restart at start", 3'd0, 48'hABCD_0100);
        respond(0, 0, 1, 16'h7, 32'h7);
        no_req("R7 parked after error");
    endtask

    task automatic t_retrig();
        tick();
        wait_req("R7 restart after error", 3'd0, 48'hABCD_0100);
        respond(0, 0, 0, 16'h1, 32'h1000);
        wait_req("R5 chain continues", 3'd0, 48'h1_0000_1000);
        wr(5'd0, 32'h40);
        respond(0, 0, 0, 16'h2, 32'h2000);
        wait_req("R6 retrigger uses start", 3'd0, 48'hABCD_0100);
        respond(0, 0, 0, 16'h3, 32'h3000);
        wait_req("R6 retrigger consumed", 3'd0, 48'h3_0000_3000);
        respond(1, 0, 0, 16'h0, 32'h0);
    endtask

    task automatic t_single();
        single_mode = 1'b1;
        tick();
        wait_req("R8 first descriptor", 3'd0, 48'hABCD_0100);
        respond(0, 0, 0, 16'h4, 32'h4444);
        no_req("R8 stop after one");
        tick();
        wait_req("R8 resume from next", 3'd0, 48'h4_0000_4444);
        respond(0, 1, 0, 16'h0, 32'h0);
        single_mode = 1'b0;
        no_req("R7 parked after frame end");
    endtask

    task automatic t_rr();
        wr(5'd25, 32'h1000);
        wr(5'd18, 32'h2);
        wr(5'd26, 32'h20);
        wr(5'd9, 32'h1);
        wr(5'd10, 32'h1);
        wr(5'd0, 32'h7);
        wait_req("R9 rr first", 3'd1, 48'h1000);
        respond(1, 0, 0, 16'h0, 32'h0);
        wait_req("R9 rr second", 3'd2, 48'h2_0020);
        respond(1, 0, 0, 16'h0, 32'h0);
        tick();
        wait_req("R9 rr wraps", 3'd0, 48'hABCD_0100);
        respond(1, 0, 0, 16'h0, 32'h0);
        wait_req("R9 rr next after ch0", 3'd1, 48'h1000);
        respond(1, 0, 0, 16'h0, 32'h0);
    endtask

    initial begin
        #1;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_regs();
        t_chain0();
        t_retrig();
        t_single();
        t_rr();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++; n_err++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule